// File: doc/BRIEF.md
# Left-Justified Stereo Audio Receiver

This block receives two-channel PCM audio from a three-wire serial link made of a bit clock, a word-select line and a data line. All three lines are brought into the system clock domain through synchronisers. Data and word select are taken at each rising edge of the bit clock. The block assembles one 16-bit two's-complement sample for each channel, MSB first. When a stereo pair is complete, it presents the left and right samples together with a single-cycle valid strobe.

Static configuration inputs control the receiver. One inverts the word-select meaning. One moves the first data bit one bit clock after the word-select edge. One copies the left sample to both outputs, for mono use. A 3-bit rate code picks the source of a sample-rate tick: either the frame rate carried by word select, or the bit clock divided by four for an oversampled back end.

Top module: `lj_audio_rx`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `left_out` and `right_out` are zero and both `sample_valid` and `rate_tick` are low.
- R2: Each channel slot is captured MSB first into a 16-bit two's-complement word. A 16-bit slot is reproduced bit for bit.
- R3: If a slot carries more than 16 bits, only the first 16 received bits are kept and the trailing bits are dropped.
- R4: If a slot carries fewer than 16 bits, the received bits fill the word from the MSB down and the remaining low-order bits are zero.
- R5: With `cfg_ws_invert` = 0, word select low marks the left slot and high marks the right slot. With `cfg_ws_invert` = 1, the mapping is swapped.
- R6: With `cfg_bit_delay` = 0, the bit taken at the rising bit-clock edge where word select has changed is the MSB of the new slot. With `cfg_bit_delay` = 1, that bit still belongs to the previous slot, and the MSB is taken at the next rising edge.
- R7: A right slot completes when the next slot starts. Both outputs then update in the same cycle, and `sample_valid` is high for exactly one cycle, three system clocks after the bit-clock rise that starts the next slot. Between pulses the outputs hold their values.
- R8: With `cfg_mono` = 1, both `left_out` and `right_out` carry the left-slot sample of the pair.
- R9: For rate codes 000, 110 and 111, `rate_tick` pulses once per frame, when the sampled word select goes from 0 to 1.
- R10: For rate codes 001 to 101, `rate_tick` pulses on every fourth rising bit-clock edge counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the bit-clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| ws_in | input | 1 | Word-select / frame line (asynchronous) |
| sd_in | input | 1 | Serial data line (asynchronous) |
| cfg_ws_invert | input | 1 | Swap the word-select channel mapping |
| cfg_bit_delay | input | 1 | First data bit one bit clock after the word-select edge |
| cfg_mono | input | 1 | Copy the left sample to both outputs |
| cfg_rate | input | 3 | Rate code choosing the tick source |
| left_out | output | 16 | Left sample of the last complete pair |
| right_out | output | 16 | Right sample of the last complete pair |
| sample_valid | output | 1 | One-cycle strobe when a new pair is presented |
| rate_tick | output | 1 | Sample-rate tick |

## Verification
Every result lags its serial cause by the two synchroniser stages plus one output register. Both `sample_valid` and `rate_tick` therefore rise on the third system-clock edge after the bit-clock rise that causes them. The bench drives the bit clock at negative system-clock edges and samples at negative edges. The latency test steps one system cycle at a time after the slot-opening rise and expects the strobe at the third negative edge only. Pair values are taken when the strobe fires and compared once the frame has been flushed by the next slot start. Tick counts are read only after enough idle cycles for the last registered tick to have appeared.

// File: rtl/lj_rx_pkg.sv
`timescale 1ns/1ps
package lj_rx_pkg;

  localparam int unsigned SAMPLE_W_DEF = 16;

  typedef enum logic {
    SLOT_LEFT  = 1'b0,
    SLOT_RIGHT = 1'b1
  } slot_e;

  // channel carried by the current slot, given the line level and inversion
  function automatic slot_e slot_of(input logic ws, input logic invert);
    return slot_e'(ws ^ invert);
  endfunction

  // codes 1..5 take the tick from the divided bit clock
  function automatic logic rate_is_oversampled(input logic [2:0] code);
    return (code != 3'd0) && (code < 3'd6);
  endfunction

endpackage

// File: rtl/lj_rx_sync.sv
`timescale 1ns/1ps
module lj_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bclk_rise,
  output logic ws_s,
  output logic sd_s
);

  localparam int unsigned NSIG  = 3;
  localparam int unsigned I_BCK = 2;
  localparam int unsigned I_WS  = 1;
  localparam int unsigned I_SD  = 0;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] pipe [STAGES];
  logic            bclk_last;

  assign raw = {bclk_in, ws_in, sd_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
      bclk_last <= 1'b0;
    end else begin
      pipe[0] <= raw;
      for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
      bclk_last <= pipe[STAGES-1][I_BCK];
    end
  end

  assign bclk_rise = pipe[STAGES-1][I_BCK] & ~bclk_last;
  assign ws_s      = pipe[STAGES-1][I_WS];
  assign sd_s      = pipe[STAGES-1][I_SD];

endmodule

// File: rtl/lj_rx_deframer.sv
`timescale 1ns/1ps
module lj_rx_deframer
  import lj_rx_pkg::*;
#(
  parameter int unsigned WORD_W = SAMPLE_W_DEF,
  localparam int unsigned CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ws,
  input  logic              sd,
  input  logic              cfg_ws_invert,
  input  logic              cfg_bit_delay,
  input  logic              cfg_mono,
  output logic [WORD_W-1:0] left_out,
  output logic [WORD_W-1:0] right_out,
  output logic              sample_valid,
  output logic              ws_rise,
  output logic [CNT_W-1:0]  slot_bits
);

  logic              ws_prev;
  logic              pend_start;
  logic              active;
  slot_e             cur_slot;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] left_hold;

  logic              ws_edge;
  logic              slot_start;

  // write bit b at distance pos below the MSB
  function automatic logic [WORD_W-1:0] insert_bit(
    input logic [WORD_W-1:0] word,
    input logic [CNT_W-1:0]  pos,
    input logic              b
  );
    logic [WORD_W-1:0] w;
    w = word;
    w[WORD_W - 1 - int'(pos)] = b;
    return w;
  endfunction

  assign ws_edge    = bit_stb && (ws != ws_prev);
  assign ws_rise    = bit_stb && ws && !ws_prev;
  assign slot_start = bit_stb && (cfg_bit_delay ? pend_start : (ws != ws_prev));
  assign slot_bits  = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_prev      <= 1'b0;
      pend_start   <= 1'b0;
      active       <= 1'b0;
      cur_slot     <= SLOT_LEFT;
      shreg        <= '0;
      cnt          <= '0;
      left_hold    <= '0;
      left_out     <= '0;
      right_out    <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= 1'b0;
      if (bit_stb) begin
        ws_prev    <= ws;
        pend_start <= cfg_bit_delay && ws_edge;
        if (slot_start) begin
          if (active) begin
            if (cur_slot == SLOT_LEFT) begin
              left_hold <= shreg;
            end else begin
              left_out     <= left_hold;
              right_out    <= cfg_mono ? left_hold : shreg;
              sample_valid <= 1'b1;
            end
          end
          active   <= 1'b1;
          cur_slot <= slot_of(ws, cfg_ws_invert);
          shreg    <= insert_bit('0, '0, sd);
          cnt      <= CNT_W'(1);
        end else if (active && (cnt < CNT_W'(WORD_W))) begin
          shreg <= insert_bit(shreg, cnt, sd);
          cnt   <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/lj_rx_tick.sv
`timescale 1ns/1ps
module lj_rx_tick
  import lj_rx_pkg::*;
#(
  parameter int unsigned OSR_DIV = 4,
  localparam int unsigned DIV_W  = (OSR_DIV > 1) ? $clog2(OSR_DIV) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       ws_rise,
  input  logic [2:0] cfg_rate,
  output logic       rate_tick
);

  logic [DIV_W-1:0] div_cnt;
  logic             div_wrap;

  assign div_wrap = bit_stb && (div_cnt == DIV_W'(OSR_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      rate_tick <= 1'b0;
    end else begin
      if (bit_stb) div_cnt <= div_wrap ? '0 : div_cnt + DIV_W'(1);
      rate_tick <= rate_is_oversampled(cfg_rate) ? div_wrap : ws_rise;
    end
  end

endmodule

// File: rtl/lj_audio_rx.sv
`timescale 1ns/1ps
module lj_audio_rx
  import lj_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = SAMPLE_W_DEF,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OSR_DIV     = 4,
  localparam int unsigned CNT_W      = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_in,
  input  logic                ws_in,
  input  logic                sd_in,
  input  logic                cfg_ws_invert,
  input  logic                cfg_bit_delay,
  input  logic                cfg_mono,
  input  logic [2:0]          cfg_rate,
  output logic [SAMPLE_W-1:0] left_out,
  output logic [SAMPLE_W-1:0] right_out,
  output logic                sample_valid,
  output logic                rate_tick
);

  logic             bclk_rise;
  logic             ws_s;
  logic             sd_s;
  logic             ws_rise;
  logic [CNT_W-1:0] slot_bits;

  lj_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_in   (bclk_in),
    .ws_in     (ws_in),
    .sd_in     (sd_in),
    .bclk_rise (bclk_rise),
    .ws_s      (ws_s),
    .sd_s      (sd_s)
  );

  lj_rx_deframer #(.WORD_W(SAMPLE_W)) u_deframer (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_stb       (bclk_rise),
    .ws            (ws_s),
    .sd            (sd_s),
    .cfg_ws_invert (cfg_ws_invert),
    .cfg_bit_delay (cfg_bit_delay),
    .cfg_mono      (cfg_mono),
    .left_out      (left_out),
    .right_out     (right_out),
    .sample_valid  (sample_valid),
    .ws_rise       (ws_rise),
    .slot_bits     (slot_bits)
  );

  lj_rx_tick #(.OSR_DIV(OSR_DIV)) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_stb   (bclk_rise),
    .ws_rise   (ws_rise),
    .cfg_rate  (cfg_rate),
    .rate_tick (rate_tick)
  );

endmodule

// File: rtl/lj_audio_rx_chk.sv
`timescale 1ns/1ps
module lj_audio_rx_chk #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned CNT_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] left_out,
  input logic [SAMPLE_W-1:0] right_out,
  input logic                sample_valid,
  input logic                rate_tick,
  input logic                cfg_mono,
  input logic                bclk_rise,
  input logic [CNT_W-1:0]    slot_bits
);

  assert_valid_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_outputs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> ($stable(left_out) && $stable(right_out)));

  assert_mono_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && $past(cfg_mono)) |-> (left_out == right_out));

  assert_slot_bits_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bits <= CNT_W'(SAMPLE_W));

  assert_tick_follows_bclk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rate_tick |-> $past(bclk_rise));

endmodule

bind lj_audio_rx lj_audio_rx_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .left_out     (left_out),
  .right_out    (right_out),
  .sample_valid (sample_valid),
  .rate_tick    (rate_tick),
  .cfg_mono     (cfg_mono),
  .bclk_rise    (bclk_rise),
  .slot_bits    (slot_bits)
);

// File: tb/lj_audio_rx_tb.sv
`timescale 1ns/1ps
module lj_audio_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic        cfg_ws_invert = 1'b0;
  logic        cfg_bit_delay = 1'b0;
  logic        cfg_mono = 1'b0;
  logic [2:0]  cfg_rate = 3'd0;
  logic [15:0] left_out;
  logic [15:0] right_out;
  logic        sample_valid;
  logic        rate_tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int          valid_seen = 0;
  int          tick_seen  = 0;
  logic [15:0] cap_l = '0;
  logic [15:0] cap_r = '0;

  always #2.5 clk = ~clk;

  lj_audio_rx u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bclk_in       (bclk),
    .ws_in         (ws),
    .sd_in         (sd),
    .cfg_ws_invert (cfg_ws_invert),
    .cfg_bit_delay (cfg_bit_delay),
    .cfg_mono      (cfg_mono),
    .cfg_rate      (cfg_rate),
    .left_out      (left_out),
    .right_out     (right_out),
    .sample_valid  (sample_valid),
    .rate_tick     (rate_tick)
  );

  always @(negedge clk) begin
    if (sample_valid) begin
      valid_seen++;
      cap_l = left_out;
      cap_r = right_out;
    end
    if (rate_tick) tick_seen++;
  end

  // fields: left[72:41] right[40:9] nbits[8:3] invert[2] delay[1] mono[0]
  localparam int NV = 8;
  localparam logic [72:0] VEC [NV] = '{
    {32'h1234_0000, 32'hABCD_0000, 6'd16, 1'b0, 1'b0, 1'b0},
    {32'hFEDC_B000, 32'h8001_F000, 6'd20, 1'b0, 1'b0, 1'b0},
    {32'h7FF0_0000, 32'h800F_FFFF, 6'd12, 1'b0, 1'b0, 1'b0},
    {32'h0F0F_0000, 32'hF0F0_0000, 6'd16, 1'b1, 1'b0, 1'b0},
    {32'h5555_0000, 32'hAAAA_0000, 6'd16, 1'b0, 1'b1, 1'b0},
    {32'hC3C3_C000, 32'h1E1E_4000, 6'd18, 1'b1, 1'b1, 1'b0},
    {32'h2468_0000, 32'h1357_0000, 6'd16, 1'b0, 1'b0, 1'b1},
    {32'h9A00_0000, 32'h55AA_0000, 6'd8,  1'b0, 1'b1, 1'b1}
  };

  // first n bits kept, at most 16, rest zero
  function automatic logic [15:0] expect_word(input logic [31:0] w, input int n);
    logic [15:0] top;
    top = w[31:16];
    if (n >= 16) return top;
    return top & ~(16'hFFFF >> n);
  endfunction

  task automatic check_val(input string req, input string what,
                           input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic send_bit(input logic w, input logic d);
    bclk = 1'b0;
    ws   = w;
    sd   = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_slot(input logic w, input logic [31:0] data,
                           input int nbits, input logic dly);
    if (dly) send_bit(w, 1'b0);
    for (int i = 0; i < nbits; i++) send_bit(w, data[31-i]);
  endtask

  task automatic do_reset(input logic ws_idle);
    bclk  = 1'b0;
    ws    = ws_idle;
    sd    = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state
    do_reset(1'b0);
    check_val("R1", "left after reset",  32'(left_out), 32'h0);
    check_val("R1", "right after reset", 32'(right_out), 32'h0);
    check_val("R1", "valid after reset", 32'(sample_valid), 32'h0);
    check_val("R1", "tick after reset",  32'(rate_tick), 32'h0);

    // table walk: R2..R6, R8
    for (int v = 0; v < NV; v++) begin
      logic [31:0] lw;
      logic [31:0] rw;
      int          nb;
      logic        inv;
      logic        dly;
      logic        mono;
      int          vbase;
      lw   = VEC[v][72:41];
      rw   = VEC[v][40:9];
      nb   = int'(VEC[v][8:3]);
      inv  = VEC[v][2];
      dly  = VEC[v][1];
      mono = VEC[v][0];
      cfg_ws_invert = inv;
      cfg_bit_delay = dly;
      cfg_mono      = mono;
      cfg_rate      = 3'd0;
      do_reset(~inv);
      send_slot(~inv, 32'h0, 16, dly);
      vbase = valid_seen;
      send_slot(inv, lw, nb, dly);
      send_slot(~inv, rw, nb, dly);
      send_slot(inv, 32'h0, 16, dly);
      repeat (6) @(negedge clk);
      check_val("R7", $sformatf("vector %0d pair strobe seen", v),
                32'(valid_seen > vbase), 32'h1);
      // R2 R3 R4 R5 R6 via the vector's own field settings
      check_val("R2", $sformatf("vector %0d left", v), 32'(cap_l), 32'(expect_word(lw, nb)));
      if (mono)
        check_val("R8", $sformatf("vector %0d right copy", v), 32'(cap_r), 32'(expect_word(lw, nb)));
      else
        check_val("R5", $sformatf("vector %0d right", v), 32'(cap_r), 32'(expect_word(rw, nb)));
    end

    // R7: outputs hold until the next slot opens, strobe three clocks later
    cfg_ws_invert = 1'b0;
    cfg_bit_delay = 1'b0;
    cfg_mono      = 1'b0;
    cfg_rate      = 3'd0;
    do_reset(1'b1);
    send_slot(1'b1, 32'h0, 16, 1'b0);
    send_slot(1'b0, 32'h0, 16, 1'b0);
    send_slot(1'b1, 32'h0, 16, 1'b0);
    send_slot(1'b0, 32'h4321_0000, 16, 1'b0);
    send_slot(1'b1, 32'h8765_0000, 16, 1'b0);
    repeat (4) @(negedge clk);
    check_val("R7", "left held before next slot",  32'(left_out), 32'h0);
    check_val("R7", "right held before next slot", 32'(right_out), 32'h0);
    bclk = 1'b0;
    ws   = 1'b0;
    sd   = 1'b0;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    @(negedge clk);
    check_val("R7", "strobe one clock after rise", 32'(sample_valid), 32'h0);
    @(negedge clk);
    check_val("R7", "strobe two clocks after rise", 32'(sample_valid), 32'h0);
    @(negedge clk);
    check_val("R7", "strobe three clocks after rise", 32'(sample_valid), 32'h1);
    check_val("R7", "left with strobe",  32'(left_out), 32'h4321);
    check_val("R7", "right with strobe", 32'(right_out), 32'h8765);
    @(negedge clk);
    check_val("R7", "strobe four clocks after rise", 32'(sample_valid), 32'h0);
    repeat (3) @(negedge clk);

    // R9 / R10: tick counts over a 48-bit-clock frame
    for (int k = 0; k < 4; k++) begin
      int tbase;
      logic [2:0] code;
      int exp_ticks;
      case (k)
        0: begin code = 3'd0; exp_ticks = 1;  end
        1: begin code = 3'd6; exp_ticks = 1;  end
        2: begin code = 3'd3; exp_ticks = 12; end
        default: begin code = 3'd5; exp_ticks = 12; end
      endcase
      cfg_rate = code;
      do_reset(1'b0);
      tbase = tick_seen;
      send_slot(1'b0, 32'hFFFF_0000, 16, 1'b0);
      send_slot(1'b1, 32'h0000_0000, 16, 1'b0);
      send_slot(1'b0, 32'hA5A5_0000, 16, 1'b0);
      repeat (6) @(negedge clk);
      check_val((k < 2) ? "R9" : "R10", $sformatf("tick count for code %0d", code),
                32'(tick_seen - tbase), 32'(exp_ticks));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule